// File: doc/BRIEF.md
# Issue-Queue Entry Wakeup with Timer Kill and Delayed Revalidation

This block holds the wakeup state of one issue-queue entry that has a left and a right source operand. Each operand keeps the tag of its producer, a ready bit and a countdown timer. When a producer's tag appears on the wakeup broadcast, the operand becomes ready and its timer is loaded with the latency that comes with the broadcast. While the timer runs, the operand sits in the shadow of a producer that may still fail, for example a load that misses in the cache.

A single kill wire, shared by every entry, tells the entry that a scheduling miss was found. Every operand whose timer is still non-zero drops its ready bit. The entry cannot tell whether it truly depends on the miss, so the kill is deliberately conservative. In squashing mode the operand then waits for a new broadcast of its producer's tag. In delayed-selective mode the operand also records the issue slot its producer used. When its timer reaches zero it looks at that slot's wire on a completion bus. It becomes ready again if the producer completed and the scoreboard reports no poison. Otherwise it stays not ready, which stops the wrong wakeups from spreading any further.

The entry requests issue when both operands are ready. A grant withdraws the request. A kill that hits either operand arms the entry again, so that it replays.

Top module: `wk_entry`

## Requirements
- R1: A wakeup broadcast whose tag equals an operand's stored tag makes that operand ready at the next clock edge. The same edge loads the operand's timer with the broadcast latency and records the broadcast issue slot.
- R2: At a clock edge where the kill wire is high, every ready operand whose timer is non-zero becomes not ready. The kill has no effect on an operand whose timer is zero.
- R3: An operand's timer falls by one at each clock edge and stays at zero once it gets there. After a wakeup with latency L at edge 0, a kill is therefore effective at edges 1 to L and has no effect from edge L+1 on.
- R4: When a kill and a matching wakeup reach the same operand at the same edge, the kill acts on the old state and the wakeup then applies. The operand ends ready, with its timer freshly loaded from the new latency.
- R5: In squashing mode (mode input 0), a killed operand stays not ready until its tag is broadcast again.
- R6: In delayed-selective mode (mode input 1), a killed operand samples completion bus bit `slot` (the recorded producer slot) and its own poison input in the cycle in which its timer is zero. If the bit is 1 and poison is 0, the operand is ready again after that edge, which is exactly one cycle after the timer reached zero.
- R7: In delayed-selective mode, a killed operand that sees its own slot's completion bit low or its poison high at that sample stays not ready. The bits of the other slots are ignored.
- R8: A wakeup broadcast whose tag differs from an operand's stored tag leaves that operand unchanged.
- R9: The issue request is high only when the entry is armed and both operands are ready.
- R10: A grant while the request is high disarms the entry, and the request stays low. A kill that clears either operand arms the entry again.
- R11: After reset, both operands are not ready and the issue request is low.
- R12: An allocation loads both tags and both initial ready bits, clears the timers and arms the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_delayed | input | 1 | 0: squashing replay, 1: delayed-selective revalidation |
| alloc_valid | input | 1 | Load a new instruction into the entry |
| alloc_tag_l | input | TAG_W | Left source producer tag |
| alloc_tag_r | input | TAG_W | Right source producer tag |
| alloc_rdy_l | input | 1 | Left source already available at allocation |
| alloc_rdy_r | input | 1 | Right source already available at allocation |
| wake_valid | input | 1 | Wakeup broadcast valid |
| wake_tag | input | TAG_W | Broadcast producer tag |
| wake_lat | input | TIMER_W | Producer latency loaded into the timer |
| wake_slot | input | SLOT_W | Issue slot the producer used |
| kill | input | 1 | Global scheduling-miss kill wire |
| cpl_bus | input | NSLOT | Completion wire, one per issue slot |
| poison_l | input | 1 | Scoreboard poison for the left source |
| poison_r | input | 1 | Scoreboard poison for the right source |
| issue_grant | input | 1 | Select logic granted this entry |
| rdy_l | output | 1 | Left source ready |
| rdy_r | output | 1 | Right source ready |
| issue_req | output | 1 | Request to issue |

## Verification
The main sweep covers both operands, both modes, latencies 1 to 3 and a kill at every edge from one past the wakeup to past the end of the timer. It also covers every producer slot, each with the completion bit on its own wire or on all other wires only, and with poison on and off. The kill position separates a live timer from an expired one and checks the exact countdown. The completion pattern shows that the revalidation samples the right slot, and does so at the right cycle. Directed sequences then check a kill that meets a wakeup at the same edge, a tag mismatch, and a grant followed by a kill that re-arms the entry.

// File: rtl/wk_pkg.sv
package wk_pkg;

    // Replay flavour selected per entry at run time.
    typedef enum logic {
        MODE_SQUASH  = 1'b0,
        MODE_DELAYED = 1'b1
    } replay_mode_e;

    // Default geometry of one entry.
    localparam int unsigned DEF_TAG_W   = 6;
    localparam int unsigned DEF_TIMER_W = 3;
    localparam int unsigned DEF_NSLOT   = 4;
    localparam int unsigned NUM_SRC     = 2;

    // What an operand should do after a kill, given the mode.
    function automatic logic wants_revalidate(replay_mode_e m);
        return m == MODE_DELAYED;
    endfunction

endpackage

// File: rtl/wk_operand.sv
module wk_operand
    import wk_pkg::*;
#(
    parameter int unsigned TAG_W   = DEF_TAG_W,
    parameter int unsigned TIMER_W = DEF_TIMER_W,
    parameter int unsigned NSLOT   = DEF_NSLOT,
    parameter int unsigned SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  replay_mode_e       mode,
    input  logic               alloc,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic               alloc_rdy,
    input  logic               wake_valid,
    input  logic [TAG_W-1:0]   wake_tag,
    input  logic [TIMER_W-1:0] wake_lat,
    input  logic [SLOT_W-1:0]  wake_slot,
    input  logic               kill,
    input  logic [NSLOT-1:0]   cpl_bus,
    input  logic               poison,
    output logic               rdy,
    output logic               kill_hit
);

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic               rdy;
        logic [TIMER_W-1:0] tmr;
        logic [SLOT_W-1:0]  slot;
        logic               pend;   // killed, waiting for the revalidation sample
    } opnd_t;

    opnd_t cur_q, nxt;

    logic match;
    logic timer_live;
    logic reval_due;
    logic reval_ok;
    logic cpl_seen;

    always_comb begin
        match      = wake_valid && (wake_tag == cur_q.tag);
        timer_live = (cur_q.tmr != '0);
        kill_hit   = kill && cur_q.rdy && timer_live;
        cpl_seen   = cpl_bus[cur_q.slot];
        reval_due  = cur_q.pend && !timer_live;
        reval_ok   = reval_due && cpl_seen && !poison;
    end

    always_comb begin
        nxt = cur_q;
        if (alloc) begin
            nxt.tag  = alloc_tag;
            nxt.rdy  = alloc_rdy;
            nxt.tmr  = '0;
            nxt.slot = '0;
            nxt.pend = 1'b0;
        end else if (match) begin
            // Kill (if any) acts on the old state; the match overrides it.
            nxt.rdy  = 1'b1;
            nxt.tmr  = wake_lat;
            nxt.slot = wake_slot;
            nxt.pend = 1'b0;
        end else begin
            nxt.tmr = timer_live ? cur_q.tmr - 1'b1 : '0;
            if (kill_hit) begin
                nxt.rdy  = 1'b0;
                nxt.pend = wants_revalidate(mode);
            end else if (reval_due) begin
                nxt.rdy  = reval_ok;
                nxt.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign rdy = cur_q.rdy;

    // R1: a tag match leaves the operand ready with the broadcast latency.
    a_r1_match_loads: assert property (@(posedge clk) disable iff (rst)
        (!alloc && match) |=> (cur_q.rdy && cur_q.tmr == $past(wake_lat)));

    // R2: a kill on a ready operand with a running timer clears it.
    a_r2_kill_clears: assert property (@(posedge clk) disable iff (rst)
        (!alloc && !match && kill && cur_q.rdy && cur_q.tmr != '0) |=> !cur_q.rdy);

    // R3: an expired timer stays at zero without a new match.
    a_r3_timer_sat: assert property (@(posedge clk) disable iff (rst)
        (!alloc && !match && cur_q.tmr == '0) |=> (cur_q.tmr == '0));

    // R5: in squashing mode a not-ready operand waits for a broadcast.
    a_r5_squash_holds: assert property (@(posedge clk) disable iff (rst)
        (!alloc && !match && !cur_q.rdy && mode == MODE_SQUASH) |=> !cur_q.rdy);

    // R7: a missing completion or a poison bit keeps the operand not ready.
    a_r7_no_reval: assert property (@(posedge clk) disable iff (rst)
        (!alloc && !match && !cur_q.rdy && (!cpl_bus[cur_q.slot] || poison)) |=> !cur_q.rdy);

endmodule

// File: rtl/wk_issue_ctl.sv
module wk_issue_ctl
    import wk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic [NUM_SRC-1:0] src_rdy,
    input  logic [NUM_SRC-1:0] src_killed,
    input  logic               grant,
    output logic               req
);

    logic armed_q;

    assign req = armed_q && (&src_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (alloc) begin
            armed_q <= 1'b1;
        end else if (|src_killed) begin
            armed_q <= 1'b1;
        end else if (grant && req) begin
            armed_q <= 1'b0;
        end
    end

    // R10: an issued entry stays quiet unless a kill replays it.
    a_r10_grant_disarms: assert property (@(posedge clk) disable iff (rst)
        (req && grant && !alloc && !(|src_killed)) |=> !req);

    // R10: a kill arms the entry again.
    a_r10_kill_rearms: assert property (@(posedge clk) disable iff (rst)
        (|src_killed) |=> armed_q);

endmodule

// File: rtl/wk_entry.sv
module wk_entry
    import wk_pkg::*;
#(
    parameter int unsigned TAG_W   = DEF_TAG_W,
    parameter int unsigned TIMER_W = DEF_TIMER_W,
    parameter int unsigned NSLOT   = DEF_NSLOT,
    localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_delayed,
    input  logic               alloc_valid,
    input  logic [TAG_W-1:0]   alloc_tag_l,
    input  logic [TAG_W-1:0]   alloc_tag_r,
    input  logic               alloc_rdy_l,
    input  logic               alloc_rdy_r,
    input  logic               wake_valid,
    input  logic [TAG_W-1:0]   wake_tag,
    input  logic [TIMER_W-1:0] wake_lat,
    input  logic [SLOT_W-1:0]  wake_slot,
    input  logic               kill,
    input  logic [NSLOT-1:0]   cpl_bus,
    input  logic               poison_l,
    input  logic               poison_r,
    input  logic               issue_grant,
    output logic               rdy_l,
    output logic               rdy_r,
    output logic               issue_req
);

    replay_mode_e mode;
    logic [TAG_W-1:0]   src_tag [NUM_SRC];
    logic [NUM_SRC-1:0] src_init;
    logic [NUM_SRC-1:0] src_poison;
    logic [NUM_SRC-1:0] src_rdy;
    logic [NUM_SRC-1:0] src_killed;

    assign mode       = replay_mode_e'(mode_delayed);
    assign src_tag[0] = alloc_tag_l;
    assign src_tag[1] = alloc_tag_r;
    assign src_init   = {alloc_rdy_r, alloc_rdy_l};
    assign src_poison = {poison_r, poison_l};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        wk_operand #(
            .TAG_W   (TAG_W),
            .TIMER_W (TIMER_W),
            .NSLOT   (NSLOT),
            .SLOT_W  (SLOT_W)
        ) u_opnd (
            .clk        (clk),
            .rst        (rst),
            .mode       (mode),
            .alloc      (alloc_valid),
            .alloc_tag  (src_tag[i]),
            .alloc_rdy  (src_init[i]),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .wake_lat   (wake_lat),
            .wake_slot  (wake_slot),
            .kill       (kill),
            .cpl_bus    (cpl_bus),
            .poison     (src_poison[i]),
            .rdy        (src_rdy[i]),
            .kill_hit   (src_killed[i])
        );
    end

    wk_issue_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc_valid),
        .src_rdy    (src_rdy),
        .src_killed (src_killed),
        .grant      (issue_grant),
        .req        (issue_req)
    );

    assign rdy_l = src_rdy[0];
    assign rdy_r = src_rdy[1];

    // R9: a request never goes out with a source missing.
    a_r9_req_needs_both: assert property (@(posedge clk) disable iff (rst)
        issue_req |-> (rdy_l && rdy_r));

    // R12: allocation takes the initial ready bits.
    a_r12_alloc_loads: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> (rdy_l == $past(alloc_rdy_l) && rdy_r == $past(alloc_rdy_r)));

endmodule

// File: tb/wk_entry_test.sv
`timescale 1ns/1ps
module wk_entry_test;

    localparam int TAG_W = 6;
    localparam int TIMER_W = 3;
    localparam int NSLOT = 4;

    logic clk = 1'b0;
    logic rst;
    logic mode_delayed, alloc_valid, alloc_rdy_l, alloc_rdy_r;
    logic [TAG_W-1:0] alloc_tag_l, alloc_tag_r, wake_tag;
    logic wake_valid, kill, poison_l, poison_r, issue_grant;
    logic [TIMER_W-1:0] wake_lat;
    logic [1:0] wake_slot;
    logic [NSLOT-1:0] cpl_bus;
    logic rdy_l, rdy_r, issue_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wk_entry #(.TAG_W(TAG_W), .TIMER_W(TIMER_W), .NSLOT(NSLOT)) uut (
        .clk(clk), .rst(rst), .mode_delayed(mode_delayed),
        .alloc_valid(alloc_valid), .alloc_tag_l(alloc_tag_l), .alloc_tag_r(alloc_tag_r),
        .alloc_rdy_l(alloc_rdy_l), .alloc_rdy_r(alloc_rdy_r),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_lat(wake_lat),
        .wake_slot(wake_slot), .kill(kill), .cpl_bus(cpl_bus),
        .poison_l(poison_l), .poison_r(poison_r), .issue_grant(issue_grant),
        .rdy_l(rdy_l), .rdy_r(rdy_r), .issue_req(issue_req)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic quiet();
        alloc_valid = 0; wake_valid = 0; kill = 0; cpl_bus = '0;
        poison_l = 0; poison_r = 0; issue_grant = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic rl, input logic rr);
        alloc_valid = 1; alloc_tag_l = 6'd5; alloc_tag_r = 6'd9;
        alloc_rdy_l = rl; alloc_rdy_r = rr;
        step();
        alloc_valid = 0;
    endtask

    task automatic do_wake(input logic [TAG_W-1:0] t, input int lat, input int slot);
        wake_valid = 1; wake_tag = t; wake_lat = TIMER_W'(lat); wake_slot = 2'(slot);
    endtask

    // One sweep case: wake operand op, kill at edge kat, completion at edge lat+1.
    task automatic run_case(input int op, input int md, input int lat, input int kat,
                            input int slot, input int good, input int pois);
        logic got;
        logic exp;
        bit eff;
        string tagname;
        mode_delayed = md[0];
        do_alloc(op == 1, op == 0);
        do_wake(op == 1 ? 6'd9 : 6'd5, lat, slot);
        step();
        wake_valid = 0;
        got = (op == 1) ? rdy_r : rdy_l;
        chk(got, 1'b1, "R1 wake sets ready");
        eff = (kat <= lat);
        for (int n = 1; n <= lat + 2; n++) begin
            kill = (n == kat);
            if (n == lat + 1)
                cpl_bus = good ? NSLOT'(1 << slot) : ~NSLOT'(1 << slot);
            else
                cpl_bus = '0;
            if (op == 1) poison_r = pois[0]; else poison_l = pois[0];
            step();
            quiet();
            if (!eff || n < kat) begin
                exp = 1; tagname = "R3 kill window";
            end else if (n <= lat) begin
                exp = 0; tagname = "R2 kill clears";
            end else begin
                exp = (md == 1 && good == 1 && pois == 0);
                tagname = (md == 0) ? "R5 squash holds" :
                          (exp ? "R6 revalidate" : "R7 no revalidate");
            end
            got = (op == 1) ? rdy_r : rdy_l;
            chk(got, exp, tagname);
            chk(issue_req, exp, "R9 request follows ready");
        end
    endtask

    initial begin
        rst = 1; mode_delayed = 0; alloc_tag_l = '0; alloc_tag_r = '0;
        alloc_rdy_l = 0; alloc_rdy_r = 0; wake_tag = '0; wake_lat = '0; wake_slot = '0;
        quiet();
        @(negedge clk);
        step(); step();
        rst = 0;
        chk(rdy_l, 1'b0, "R11 reset left");
        chk(rdy_r, 1'b0, "R11 reset right");
        chk(issue_req, 1'b0, "R11 reset request");

        // R12: allocate with both ready; request rises, zero timers ignore kill (R2).
        do_alloc(1, 1);
        chk(issue_req, 1'b1, "R12 alloc arms and loads ready");
        kill = 1; step(); kill = 0;
        chk(rdy_l, 1'b1, "R2 zero timer ignores kill");

        // R8: mismatching tag.
        do_alloc(0, 1);
        do_wake(6'd6, 2, 0); step(); wake_valid = 0;
        chk(rdy_l, 1'b0, "R8 mismatch ignored");
        chk(issue_req, 1'b0, "R8 no request");

        // R4: kill and match together.
        mode_delayed = 0;
        do_alloc(0, 1);
        do_wake(6'd5, 1, 0); step();
        kill = 1; do_wake(6'd5, 3, 0); step(); quiet();
        chk(rdy_l, 1'b1, "R4 match wins over kill");
        step();
        kill = 1; step(); kill = 0;
        chk(rdy_l, 1'b0, "R4 fresh timer still running");

        // R10: grant disarms, kill re-arms.
        do_alloc(0, 1);
        do_wake(6'd5, 3, 0); step(); wake_valid = 0;
        chk(issue_req, 1'b1, "R9 both ready");
        issue_grant = 1; step(); issue_grant = 0;
        chk(issue_req, 1'b0, "R10 grant clears request");
        chk(rdy_l, 1'b1, "R10 operand still ready");
        kill = 1; step(); kill = 0;
        chk(rdy_l, 1'b0, "R10 kill clears issued source");
        do_wake(6'd5, 1, 0); step(); wake_valid = 0;
        chk(issue_req, 1'b1, "R10 kill re-armed entry");

        for (int op = 0; op < 2; op++)
            for (int md = 0; md < 2; md++)
                for (int lat = 1; lat <= 3; lat++)
                    for (int kat = 1; kat <= 4; kat++)
                        for (int slot = 0; slot < NSLOT; slot++)
                            for (int good = 0; good < 2; good++)
                                for (int pois = 0; pois < 2; pois++)
                                    run_case(op, md, lat, kat, slot, good, pois);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule